// File: doc/BRIEF.md
# Opcode Dispatch Table Unit

The block turns one-byte machine opcodes into entry addresses of a microprogram. A microsequencer reads these addresses. Each mapping lives in writable table RAM. Every stored word holds a 15-bit microaddress and one parity bit, and each lookup checks that parity. The unit keeps several table sets. A set register, loaded at each context switch, chooses which set answers lookups. This lets one machine run more than one instruction set. It also lets kernel and user code see different tables, for example to trap privileged opcodes in user mode.

The opcode byte 0xFF is reserved as an escape. It produces no result of its own. Instead it steers the next opcode byte into the extension table of the active set, which gives each set 256 more operations. Lookups are pipelined with one register stage. An opcode is presented while the current instruction still executes, and its entry address appears on the next cycle.

Top module: `opcode_dispatch`

## Requirements
- R1: A valid opcode other than 0xFF, with no escape pending, returns the base-table entry of the active set on the next cycle with `ua_valid` high.
- R2: A table word is `{parity, uaddr[14:0]}`. The loader supplies the parity bit, and a word is good when its 16 bits hold an even number of ones.
- R3: A lookup that reads a word with odd parity raises `par_err` for one cycle, holds `ua_valid` low and drives `uaddr` to the trap address 0.
- R4: The byte 0xFF, taken with no escape pending, gives no result on the next cycle. The next valid byte, 0xFF included, is looked up in the extension table of the active set, and the escape is then over.
- R5: A `ctx_switch` pulse loads `ctx_set` into the set register, which reset clears to 0. Lookups from the next cycle onward use the new set, and a lookup in the switch cycle still uses the old set.
- R6: A context switch cancels a pending escape. An escape byte given in the same cycle as a switch is dropped, so the next byte goes to the base table.
- R7: When a table write and a lookup hit the same entry in the same cycle, the lookup returns the old word. The new word is seen from the next cycle.
- R8: After reset, `ua_valid` and `par_err` are low and `uaddr` is 0.
- R9: A cycle without `op_valid` gives no result on the next cycle and leaves a pending escape in place.
- R10: A write reaches only the entry chosen by `wr_set`, `wr_ext` (1 = extension table) and `wr_index`. Every other entry of every set keeps its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode byte present this cycle |
| op_byte | input | 8 | Opcode byte |
| ctx_switch | input | 1 | Load the set register from `ctx_set` |
| ctx_set | input | 2 | Table set for the new context |
| wr_en | input | 1 | Write one table word |
| wr_set | input | 2 | Set being written |
| wr_ext | input | 1 | 0 = base table, 1 = extension table |
| wr_index | input | 8 | Entry index being written |
| wr_uaddr | input | 15 | Microaddress to store |
| wr_par | input | 1 | Parity bit to store |
| ua_valid | output | 1 | Entry address on `uaddr` is good |
| uaddr | output | 15 | Microprogram entry address, or 0 on error |
| par_err | output | 1 | Parity failure on the last lookup |

## Verification
The assertions check some rules on every cycle. Valid and error are never high together. An error always carries the trap address. Each issued lookup yields exactly one result on the next cycle, and idle or escape cycles yield none. They also check how the set register loads and holds, and how the escape flag is set, kept across idle cycles and cleared by a switch. Only the bench scenarios can show that the right word comes back. To do that, the bench sweeps every entry of every base and extension table against its own model. The bench also shows the old word returned when a write and a lookup collide, and the old set used when a lookup shares a cycle with a switch.

// File: rtl/opdisp_pkg.sv
package opdisp_pkg;

  typedef enum logic {
    TBL_BASE = 1'b0,
    TBL_EXT  = 1'b1
  } tbl_kind_e;

  // True when the word (zero extended) holds an even count of ones.
  function automatic logic word_even(input logic [63:0] w);
    return ~(^w);
  endfunction

  // Row inside one set's storage: extension rows sit above base rows.
  function automatic logic [15:0] row_of(input tbl_kind_e kind, input logic [7:0] idx);
    return {7'd0, (kind == TBL_EXT), idx};
  endfunction

endpackage

// File: rtl/opdisp_bank.sv
module opdisp_bank #(
  parameter int ROW_W   = 9,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ROW_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [ROW_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  // Read sees the word held before any write at this same edge.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/opdisp_front.sv
module opdisp_front
  import opdisp_pkg::*;
#(
  parameter int              OP_W   = 8,
  parameter int              SET_W  = 2,
  parameter logic [OP_W-1:0] ESC_OP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_byte,
  input  logic             ctx_switch,
  input  logic [SET_W-1:0] ctx_set,
  output logic [SET_W-1:0] cur_set,
  output logic             esc_pend,
  output logic             esc_hit,
  output logic             lookup_fire,
  output tbl_kind_e        lookup_kind
);
  assign esc_hit     = op_valid && !esc_pend && (op_byte == ESC_OP);
  assign lookup_fire = op_valid && !esc_hit;
  assign lookup_kind = esc_pend ? TBL_EXT : TBL_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_set  <= '0;
      esc_pend <= 1'b0;
    end else begin
      if (ctx_switch) cur_set <= ctx_set;
      if (ctx_switch)    esc_pend <= 1'b0;
      else if (op_valid) esc_pend <= esc_hit;
    end
  end
endmodule

// File: rtl/opdisp_result.sv
module opdisp_result
  import opdisp_pkg::*;
#(
  parameter int                 UADDR_W    = 15,
  parameter logic [UADDR_W-1:0] TRAP_UADDR = '0
) (
  input  logic               rd_vld,
  input  logic [UADDR_W:0]   rd_word,
  output logic               ua_valid,
  output logic [UADDR_W-1:0] uaddr,
  output logic               par_err
);
  logic word_ok;

  assign word_ok  = word_even(64'(rd_word));
  assign ua_valid = rd_vld && word_ok;
  assign par_err  = rd_vld && !word_ok;
  assign uaddr    = ua_valid ? rd_word[UADDR_W-1:0] : TRAP_UADDR;
endmodule

// File: rtl/opcode_dispatch.sv
module opcode_dispatch
  import opdisp_pkg::*;
#(
  parameter int                 NUM_SETS   = 4,
  parameter int                 OP_W       = 8,
  parameter int                 UADDR_W    = 15,
  parameter logic [OP_W-1:0]    ESC_OP     = '1,
  parameter logic [UADDR_W-1:0] TRAP_UADDR = '0,
  localparam int                SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [OP_W-1:0]    op_byte,
  input  logic               ctx_switch,
  input  logic [SET_W-1:0]   ctx_set,
  input  logic               wr_en,
  input  logic [SET_W-1:0]   wr_set,
  input  logic               wr_ext,
  input  logic [OP_W-1:0]    wr_index,
  input  logic [UADDR_W-1:0] wr_uaddr,
  input  logic               wr_par,
  output logic               ua_valid,
  output logic [UADDR_W-1:0] uaddr,
  output logic               par_err
);
  localparam int ROW_W   = OP_W + 1;
  localparam int ENTRY_W = UADDR_W + 1;

  logic [SET_W-1:0]   cur_set;
  logic               esc_pend;
  logic               esc_hit;
  logic               lookup_fire;
  tbl_kind_e          lookup_kind;
  logic [ROW_W-1:0]   rd_row;
  logic [ROW_W-1:0]   wr_row;
  logic [ENTRY_W-1:0] wr_word;
  logic               rd_vld;
  logic [SET_W-1:0]   rd_set;
  logic [ENTRY_W-1:0] bank_rd [NUM_SETS];
  logic [ENTRY_W-1:0] rd_word;

  opdisp_front #(.OP_W(OP_W), .SET_W(SET_W), .ESC_OP(ESC_OP)) u_front (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .ctx_switch(ctx_switch), .ctx_set(ctx_set), .cur_set(cur_set),
    .esc_pend(esc_pend), .esc_hit(esc_hit), .lookup_fire(lookup_fire),
    .lookup_kind(lookup_kind)
  );

  assign rd_row  = {(lookup_kind == TBL_EXT), op_byte};
  assign wr_row  = {wr_ext, wr_index};
  assign wr_word = {wr_par, wr_uaddr};

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      opdisp_bank #(.ROW_W(ROW_W), .ENTRY_W(ENTRY_W)) u_bank (
        .clk(clk),
        .we(wr_en && (wr_set == SET_W'(g))),
        .waddr(wr_row),
        .wdata(wr_word),
        .re(lookup_fire && (cur_set == SET_W'(g))),
        .raddr(rd_row),
        .rdata(bank_rd[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_set <= '0;
    end else begin
      rd_vld <= lookup_fire;
      if (lookup_fire) rd_set <= cur_set;
    end
  end

  assign rd_word = bank_rd[rd_set];

  opdisp_result #(.UADDR_W(UADDR_W), .TRAP_UADDR(TRAP_UADDR)) u_result (
    .rd_vld(rd_vld), .rd_word(rd_word),
    .ua_valid(ua_valid), .uaddr(uaddr), .par_err(par_err)
  );
endmodule

// File: rtl/opcode_dispatch_sva.sv
module opcode_dispatch_sva #(
  parameter int                 SET_W      = 2,
  parameter int                 UADDR_W    = 15,
  parameter logic [UADDR_W-1:0] TRAP_UADDR = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               ctx_switch,
  input logic [SET_W-1:0]   ctx_set,
  input logic               ua_valid,
  input logic [UADDR_W-1:0] uaddr,
  input logic               par_err,
  input logic               lookup_fire,
  input logic               esc_hit,
  input logic               esc_pend,
  input logic [SET_W-1:0]   cur_set
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ua_valid && par_err));

  p_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (uaddr == TRAP_UADDR));

  p_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire |=> (ua_valid || par_err));

  p_noresult_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_fire |=> !(ua_valid || par_err));

  p_escape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_hit && !ctx_switch) |=> esc_pend);

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_pend && !op_valid && !ctx_switch) |=> esc_pend);

  p_ctx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> !esc_pend);

  p_set_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> (cur_set == $past(ctx_set)));

  p_set_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_switch |=> $stable(cur_set));
endmodule

bind opcode_dispatch opcode_dispatch_sva #(
  .SET_W(SET_W), .UADDR_W(UADDR_W), .TRAP_UADDR(TRAP_UADDR)
) u_sva (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ctx_switch(ctx_switch),
  .ctx_set(ctx_set), .ua_valid(ua_valid), .uaddr(uaddr), .par_err(par_err),
  .lookup_fire(lookup_fire), .esc_hit(esc_hit), .esc_pend(esc_pend),
  .cur_set(cur_set)
);

// File: tb/opcode_dispatch_test.sv
module opcode_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = '0;
  logic        ctx_switch = 1'b0;
  logic [1:0]  ctx_set = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_set = '0;
  logic        wr_ext = 1'b0;
  logic [7:0]  wr_index = '0;
  logic [14:0] wr_uaddr = '0;
  logic        wr_par = 1'b0;
  logic        ua_valid;
  logic [14:0] uaddr;
  logic        par_err;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  logic [14:0] model [4][2][256];

  opcode_dispatch uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .ctx_switch(ctx_switch), .ctx_set(ctx_set), .wr_en(wr_en),
    .wr_set(wr_set), .wr_ext(wr_ext), .wr_index(wr_index),
    .wr_uaddr(wr_uaddr), .wr_par(wr_par), .ua_valid(ua_valid),
    .uaddr(uaddr), .par_err(par_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] gen(input int s, input int e, input int i);
    int v;
    v = (s * 3001 + e * 911 + i * 53 + 7) % 32768;
    return v[14:0];
  endfunction

  function automatic logic par_of(input logic [14:0] a);
    int c;
    c = 0;
    for (int k = 0; k < 15; k++) c += int'(a[k]);
    return (c % 2) == 1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic ev, input logic ee, input logic [14:0] ea,
                       input string req);
    n_chk++;
    if (ua_valid !== ev || par_err !== ee || uaddr !== ea) begin
      n_err++;
      $display("FAIL %s: got valid=%0b err=%0b uaddr=%h, expected valid=%0b err=%0b uaddr=%h",
               req, ua_valid, par_err, uaddr, ev, ee, ea);
    end
  endtask

  task automatic write(input int s, input int e, input int i,
                       input logic [14:0] a, input logic bad);
    wr_en = 1'b1; wr_set = s[1:0]; wr_ext = e[0]; wr_index = i[7:0];
    wr_uaddr = a; wr_par = par_of(a) ^ bad;
    tick();
    wr_en = 1'b0;
    if (!bad) model[s][e][i] = a;
  endtask

  task automatic lookup(input logic [7:0] b);
    op_valid = 1'b1; op_byte = b;
    tick();
    op_valid = 1'b0;
  endtask

  task automatic switch_to(input int s);
    ctx_switch = 1'b1; ctx_set = s[1:0];
    tick();
    ctx_switch = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check(1'b0, 1'b0, 15'd0, "R8 reset outputs");
    rst_n = 1'b1;
    tick();
    check(1'b0, 1'b0, 15'd0, "R8 after release");

    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int i = 0; i < 256; i++)
          write(s, e, i, gen(s, e, i), 1'b0);

    // Set register starts at 0 after reset
    lookup(8'h10);
    check(1'b1, 1'b0, gen(0, 0, 16), "R5 reset set is 0");

    // Full sweep of every table (R1, R4, R10)
    for (int s = 0; s < 4; s++) begin
      switch_to(s);
      check(1'b0, 1'b0, 15'd0, "R9 switch cycle gives no result");
      for (int i = 0; i < 255; i++) begin
        lookup(i[7:0]);
        check(1'b1, 1'b0, model[s][0][i], "R1 base lookup");
      end
      for (int i = 0; i < 256; i++) begin
        lookup(8'hFF);
        check(1'b0, 1'b0, 15'd0, "R4 escape gives no result");
        lookup(i[7:0]);
        check(1'b1, 1'b0, model[s][1][i], "R4 extension lookup");
      end
    end

    // Escape survives idle cycles, then ends after one byte
    switch_to(1);
    lookup(8'hFF);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(1'b0, 1'b0, 15'd0, "R9 idle gives no result");
    end
    lookup(8'h22);
    check(1'b1, 1'b0, model[1][1][34], "R9 escape kept over idle");
    lookup(8'h22);
    check(1'b1, 1'b0, model[1][0][34], "R4 escape ends after one byte");
    lookup(8'hFF);
    lookup(8'hFF);
    check(1'b1, 1'b0, model[1][1][255], "R4 0xFF after escape is extension entry");

    // Context switch cancels a pending escape
    lookup(8'hFF);
    switch_to(3);
    lookup(8'h05);
    check(1'b1, 1'b0, model[3][0][5], "R6 switch cancels escape");
    ctx_switch = 1'b1; ctx_set = 2'd2; op_valid = 1'b1; op_byte = 8'hFF;
    tick();
    ctx_switch = 1'b0; op_valid = 1'b0;
    check(1'b0, 1'b0, 15'd0, "R6 escape in switch cycle dropped");
    lookup(8'h05);
    check(1'b1, 1'b0, model[2][0][5], "R6 byte after dropped escape uses base");

    // Lookup in the switch cycle uses the old set
    ctx_switch = 1'b1; ctx_set = 2'd0; op_valid = 1'b1; op_byte = 8'h30;
    tick();
    ctx_switch = 1'b0; op_valid = 1'b0;
    check(1'b1, 1'b0, model[2][0][48], "R5 old set in switch cycle");
    lookup(8'h30);
    check(1'b1, 1'b0, model[0][0][48], "R5 new set after switch");

    // Write and lookup of the same entry in one cycle
    wr_en = 1'b1; wr_set = 2'd0; wr_ext = 1'b0; wr_index = 8'h40;
    wr_uaddr = 15'h1234; wr_par = par_of(15'h1234);
    op_valid = 1'b1; op_byte = 8'h40;
    tick();
    wr_en = 1'b0; op_valid = 1'b0;
    check(1'b1, 1'b0, model[0][0][64], "R7 old word on collision");
    model[0][0][64] = 15'h1234;
    lookup(8'h40);
    check(1'b1, 1'b0, 15'h1234, "R7 new word next cycle");
    switch_to(1);
    lookup(8'h40);
    check(1'b1, 1'b0, model[1][0][64], "R10 other set untouched");
    lookup(8'hFF);
    lookup(8'h40);
    check(1'b1, 1'b0, model[1][1][64], "R10 extension table untouched");
    switch_to(0);

    // Parity failures in base and extension tables
    write(0, 0, 65, 15'h2AAA, 1'b1);
    lookup(8'h41);
    check(1'b0, 1'b1, 15'd0, "R3 base parity error traps");
    tick();
    check(1'b0, 1'b0, 15'd0, "R3 error lasts one cycle");
    write(0, 1, 7, 15'h0F0F, 1'b1);
    lookup(8'hFF);
    lookup(8'h07);
    check(1'b0, 1'b1, 15'd0, "R3 extension parity error traps");
    lookup(8'h42);
    check(1'b1, 1'b0, model[0][0][66], "R3 next lookup clean");
    write(0, 0, 65, 15'h2AAA, 1'b0);
    lookup(8'h41);
    check(1'b1, 1'b0, 15'h2AAA, "R2 rewritten even-parity word good");
    write(0, 0, 66, 15'h0001, 1'b0);
    lookup(8'h42);
    check(1'b1, 1'b0, 15'h0001, "R2 parity bit set word good");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule